// File: doc/BRIEF.md
# Indirect I/O Window onto a Shared Byte Buffer

This block is an 8-bit ISA I/O slave that lets a host reach a 4 KB on-board byte buffer through only three consecutive I/O ports. The host loads a 12-bit buffer pointer in two steps. An I/O write to the base port stores the pointer's low byte, and an I/O write to the next port stores its high byte. A read or write at the third port then moves one byte between the data bus and the buffer location the pointer names. The pointer is never changed by a data access, so a host may read and then rewrite the same location without reloading it.

Ten address lines, the eight-bit data bus and the active-low IOR and IOW strobes are sampled on the board clock. The block decodes all ten address lines against a base of 308H. It drives the buffer select, read enable, write enable and pointer, and it holds a buffer model of its own.

Top module: `isa_io_window`

## Requirements
- R1: After reset both pointer bytes are 00H, and the data bus enable, buffer select, buffer read and buffer write are all low.
- R2: An I/O write to 308H stores the data bus in the pointer's low byte, and an I/O read of 308H returns that byte with the data bus enabled.
- R3: An I/O write to 309H stores all 8 data bits in the pointer's high byte, and an I/O read of 309H returns all 8 bits. Only bits 3:0 of the high byte form buffer address bits 11:8, and the low byte forms bits 7:0.
- R4: An I/O write to 30AH stores the data byte at the pointed buffer location. The write enable is high for exactly one clock per IOW assertion, however long IOW stays low.
- R5: An I/O read of 30AH returns the byte at the pointed location in the same cycle. The buffer select is high only while IOR or IOW is low at 30AH, and the buffer read is high only while IOR is low at 30AH.
- R6: The data bus enable is high only while IOR is low at 308H, 309H or 30AH. When the enable is low, the data output is 00H.
- R7: A data access at 30AH leaves both pointer bytes unchanged; there is no auto-increment.
- R8: An I/O write to any address other than the three ports, including an address that differs only in bits 9:8, changes neither pointer byte nor the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rstN | input | 1 | Active-low synchronous reset |
| isaAddr | input | 10 | I/O address lines |
| isaDataIn | input | 8 | Data bus from host |
| iorN | input | 1 | I/O read strobe, active low |
| iowN | input | 1 | I/O write strobe, active low |
| isaDataOut | output | 8 | Data bus to host |
| isaDataOe | output | 1 | Data bus drive enable |
| bufCs | output | 1 | Buffer select |
| bufRd | output | 1 | Buffer read enable |
| bufWr | output | 1 | Buffer write enable |
| bufAddr | output | 12 | Buffer address from the pointer |

## Verification
Read results are combinational. Read data, the enable, the select and the read enable are therefore due in the same cycle that IOR and the address are applied. The bench drives them at the falling clock edge and samples a few nanoseconds later. Pointer and buffer updates take effect at the first rising edge with IOW low. Every write task releases IOW at the next falling edge, and the read that checks the write comes after that. The single write pulse is counted over a strobe held for several cycles.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;
  typedef struct packed {
    logic loadLo;
    logic loadHi;
    logic bufSel;
    logic bufRead;
    logic bufWrite;
    logic drvLo;
    logic drvHi;
    logic drvBuf;
  } winStrobe_t;

  localparam int PORT_LO  = 0;
  localparam int PORT_HI  = 1;
  localparam int PORT_DAT = 2;
  localparam int PORT_CNT = 3;
endpackage

// File: rtl/isa_win_ctrl.sv
module isa_win_ctrl
  import isa_win_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] BASE = 10'h308
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] isaAddr,
  input  logic              iorN,
  input  logic              iowN,
  output winStrobe_t        stb
);
  logic [PORT_CNT-1:0] hit;
  logic iowPrevN;
  logic iowEdge;
  logic rdAct;

  for (genvar i = 0; i < PORT_CNT; i++) begin : g_dec
    assign hit[i] = (isaAddr == BASE + ADDR_W'(i));
  end

  // remember last strobe level so a long IOW acts only once
  always_ff @(posedge clk) begin
    if (!rstN) iowPrevN <= 1'b1;
    else       iowPrevN <= iowN;
  end

  assign iowEdge = !iowN && iowPrevN;
  assign rdAct   = !iorN;

  always_comb begin
    stb          = '0;
    stb.loadLo   = iowEdge && hit[PORT_LO];
    stb.loadHi   = iowEdge && hit[PORT_HI];
    stb.bufWrite = iowEdge && hit[PORT_DAT];
    stb.bufRead  = rdAct && hit[PORT_DAT];
    stb.bufSel   = (rdAct || !iowN) && hit[PORT_DAT];
    stb.drvLo    = rdAct && hit[PORT_LO];
    stb.drvHi    = rdAct && hit[PORT_HI];
    stb.drvBuf   = rdAct && hit[PORT_DAT];
  end
endmodule

// File: rtl/isa_win_dp.sv
module isa_win_dp
  import isa_win_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int BUF_AW = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobe_t        stb,
  input  logic [DATA_W-1:0] isaDataIn,
  input  logic [DATA_W-1:0] bufRdData,
  output logic [BUF_AW-1:0] bufAddr,
  output logic [DATA_W-1:0] isaDataOut,
  output logic              isaDataOe
);
  localparam int HI_USED = BUF_AW - DATA_W;

  logic [DATA_W-1:0] ptrLo;
  logic [DATA_W-1:0] ptrHi;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrLo <= '0;
      ptrHi <= '0;
    end else begin
      if (stb.loadLo) ptrLo <= isaDataIn;
      if (stb.loadHi) ptrHi <= isaDataIn;
    end
  end

  assign bufAddr = {ptrHi[HI_USED-1:0], ptrLo};

  always_comb begin
    isaDataOe  = stb.drvLo || stb.drvHi || stb.drvBuf;
    isaDataOut = '0;
    if (stb.drvLo)       isaDataOut = ptrLo;
    else if (stb.drvHi)  isaDataOut = ptrHi;
    else if (stb.drvBuf) isaDataOut = bufRdData;
  end
endmodule

// File: rtl/isa_win_buf.sv
module isa_win_buf #(
  parameter int DATA_W = 8,
  parameter int BUF_AW = 12
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [BUF_AW-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << BUF_AW;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wrData;
  end

  assign rdData = mem[addr];
endmodule

// File: rtl/isa_io_window.sv
module isa_io_window
  import isa_win_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int BUF_AW = 12,
  parameter logic [ADDR_W-1:0] BASE = 10'h308
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] isaAddr,
  input  logic [DATA_W-1:0] isaDataIn,
  input  logic              iorN,
  input  logic              iowN,
  output logic [DATA_W-1:0] isaDataOut,
  output logic              isaDataOe,
  output logic              bufCs,
  output logic              bufRd,
  output logic              bufWr,
  output logic [BUF_AW-1:0] bufAddr
);
  winStrobe_t        stb;
  logic [DATA_W-1:0] bufRdData;

  isa_win_ctrl #(.ADDR_W(ADDR_W), .BASE(BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .isaAddr(isaAddr),
    .iorN(iorN), .iowN(iowN), .stb(stb)
  );

  isa_win_dp #(.DATA_W(DATA_W), .BUF_AW(BUF_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .isaDataIn(isaDataIn),
    .bufRdData(bufRdData), .bufAddr(bufAddr),
    .isaDataOut(isaDataOut), .isaDataOe(isaDataOe)
  );

  isa_win_buf #(.DATA_W(DATA_W), .BUF_AW(BUF_AW)) u_buf (
    .clk(clk), .wrEn(stb.bufWrite), .addr(bufAddr),
    .wrData(isaDataIn), .rdData(bufRdData)
  );

  assign bufCs = stb.bufSel;
  assign bufRd = stb.bufRead;
  assign bufWr = stb.bufWrite;
endmodule

// File: rtl/isa_win_chk.sv
module isa_win_chk #(
  parameter int BUF_AW = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              iorN,
  input logic              iowN,
  input logic              isaDataOe,
  input logic              bufCs,
  input logic              bufRd,
  input logic              bufWr,
  input logic [BUF_AW-1:0] bufAddr
);
  assert_oe_needs_ior_R6: assert property (@(posedge clk) disable iff (!rstN)
    isaDataOe |-> !iorN);

  assert_cs_needs_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufCs |-> (!iorN || !iowN));

  assert_rd_inside_cs_R5: assert property (@(posedge clk) disable iff (!rstN)
    bufRd |-> (bufCs && !iorN));

  assert_single_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    bufWr |=> !bufWr);

  assert_wr_inside_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    bufWr |-> (bufCs && !iowN));

  assert_ptr_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(iowN) |-> $stable(bufAddr));
endmodule

bind isa_io_window isa_win_chk #(.BUF_AW(BUF_AW)) u_chk (
  .clk(clk), .rstN(rstN), .iorN(iorN), .iowN(iowN),
  .isaDataOe(isaDataOe), .bufCs(bufCs), .bufRd(bufRd),
  .bufWr(bufWr), .bufAddr(bufAddr)
);

// File: tb/test_isa_io_window.sv
module test_isa_io_window;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [9:0] isaAddr = '0;
  logic [7:0] isaDataIn = '0;
  logic       iorN = 1'b1;
  logic       iowN = 1'b1;
  logic [7:0] isaDataOut;
  logic       isaDataOe;
  logic       bufCs, bufRd, bufWr;
  logic [11:0] bufAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  isa_io_window i_isa_io_window (
    .clk(clk), .rstN(rstN), .isaAddr(isaAddr), .isaDataIn(isaDataIn),
    .iorN(iorN), .iowN(iowN), .isaDataOut(isaDataOut), .isaDataOe(isaDataOe),
    .bufCs(bufCs), .bufRd(bufRd), .bufWr(bufWr), .bufAddr(bufAddr)
  );

  // vector: {req[3:0], op[3:0] (0 write, 1 read), addr[11:0], data[7:0], expect[7:0]}
  localparam int NV = 22;
  localparam logic [35:0] VEC [NV] = '{
    {4'd2, 4'd0, 12'h308, 8'h34, 8'h00},  // R2 load low
    {4'd3, 4'd0, 12'h309, 8'hF2, 8'h00},  // R3 load high
    {4'd2, 4'd1, 12'h308, 8'h00, 8'h34},  // R2 read low
    {4'd3, 4'd1, 12'h309, 8'h00, 8'hF2},  // R3 all bits back
    {4'd4, 4'd0, 12'h30A, 8'h5A, 8'h00},  // R4 store at 234
    {4'd2, 4'd0, 12'h308, 8'h35, 8'h00},
    {4'd4, 4'd0, 12'h30A, 8'hA5, 8'h00},  // R4 store at 235
    {4'd2, 4'd0, 12'h308, 8'h34, 8'h00},
    {4'd5, 4'd1, 12'h30A, 8'h00, 8'h5A},  // R5 read 234
    {4'd3, 4'd0, 12'h309, 8'h02, 8'h00},  // R3 upper nibble dropped
    {4'd3, 4'd1, 12'h30A, 8'h00, 8'h5A},  // R3 still 234
    {4'd3, 4'd1, 12'h309, 8'h00, 8'h02},
    {4'd2, 4'd0, 12'h308, 8'h35, 8'h00},
    {4'd5, 4'd1, 12'h30A, 8'h00, 8'hA5},  // R5 read 235
    {4'd2, 4'd0, 12'h308, 8'hFF, 8'h00},
    {4'd3, 4'd0, 12'h309, 8'h0F, 8'h00},
    {4'd4, 4'd0, 12'h30A, 8'h77, 8'h00},  // R4 top location
    {4'd5, 4'd1, 12'h30A, 8'h00, 8'h77},
    {4'd7, 4'd1, 12'h308, 8'h00, 8'hFF},  // R7 no increment
    {4'd8, 4'd0, 12'h30B, 8'h99, 8'h00},  // R8 neighbour ignored
    {4'd8, 4'd0, 12'h108, 8'h11, 8'h00},  // R8 alias in bits 9:8 ignored
    {4'd8, 4'd1, 12'h308, 8'h00, 8'hFF}   // R8 low byte intact
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ioWrite(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    isaAddr = a; isaDataIn = d; iowN = 1'b0;
    @(negedge clk);
    iowN = 1'b1;
  endtask

  task automatic ioRead(input logic [9:0] a, output logic [7:0] d, output logic oe,
                        output logic cs, output logic rd);
    @(negedge clk);
    isaAddr = a; iorN = 1'b0;
    #3;
    d = isaDataOut; oe = isaDataOe; cs = bufCs; rd = bufRd;
    @(negedge clk);
    iorN = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic oe, cs, rd;
    int pulses;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 oe", isaDataOe, 0);
    check("R1 cs", bufCs, 0);
    check("R1 wr", bufWr, 0);
    check("R1 rd", bufRd, 0);
    rstN = 1'b1;
    ioRead(10'h308, d, oe, cs, rd);
    check("R1 low", d, 8'h00);
    ioRead(10'h309, d, oe, cs, rd);
    check("R1 high", d, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][31:28] == 4'd0) begin
        ioWrite(VEC[i][25:16], VEC[i][15:8]);
      end else begin
        ioRead(VEC[i][25:16], d, oe, cs, rd);
        total++;
        if (d !== VEC[i][7:0] || oe !== 1'b1) begin
          bad++;
          $display("FAIL R%0d vec %0d actual=%0h oe=%0b expected=%0h oe=1",
                   VEC[i][35:32], i, d, oe, VEC[i][7:0]);
        end
      end
    end

    // R4: long write strobe gives a single write pulse
    @(negedge clk);
    isaAddr = 10'h30A; isaDataIn = 8'hC3; iowN = 1'b0;
    pulses = 0;
    for (int k = 0; k < 4; k++) begin
      #3; if (bufWr) pulses++;
      check("R5 cs on write", bufCs, 1);
      @(negedge clk);
    end
    iowN = 1'b1;
    check("R4 pulses", pulses, 1);
    ioRead(10'h30A, d, oe, cs, rd);
    check("R4 data", d, 8'hC3);
    check("R5 cs on read", cs, 1);
    check("R5 rd on read", rd, 1);
    check("R7 addr", bufAddr, 12'hFFF);

    // R5/R6: pointer port read does not select buffer; foreign port stays off
    ioRead(10'h308, d, oe, cs, rd);
    check("R5 cs at ptr", cs, 0);
    check("R6 oe at ptr", oe, 1);
    ioRead(10'h30B, d, oe, cs, rd);
    check("R6 oe foreign", oe, 0);
    check("R6 data foreign", d, 8'h00);
    check("R5 cs foreign", cs, 0);
    ioRead(10'h10A, d, oe, cs, rd);
    check("R6 oe alias", oe, 0);
    // R6: write cycle at a port does not enable the bus
    @(negedge clk);
    isaAddr = 10'h309; isaDataIn = 8'h0F; iowN = 1'b0;
    #3;
    check("R6 oe on write", isaDataOe, 0);
    @(negedge clk);
    iowN = 1'b1;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule